// File: doc/BRIEF.md
# SPI Receive Word Queue

This block holds words that an SPI shift register has finished receiving until a register read port collects them. It is a small circular queue of 32-bit words with an entry count and a read index, both brought out as 4-bit status fields. Each debug index selects one stored slot, which can be read at any time without disturbing the queue.

When a word arrives while the queue is full, a sticky overflow flag is raised. A configuration input then decides the outcome. In drop mode the arriving word is lost. In overwrite mode the arriving word replaces the most recently stored word. A second sticky flag, the drain flag, asks for the queue to be emptied. Both flags are cleared by writing a mask in which a 1 clears the flag at that bit position. A request-enable mask uses the same bit positions. The drain request can be steered to a DMA request line or to the interrupt line. A flush command empties the queue in a single cycle. A bypass input shrinks the queue to a single slot.

A small control state machine tracks the fill level in three states. EMPTY holds no words. PARTIAL holds some words but has room. FULL holds as many words as the current capacity allows. The transitions are push-to-partial, push-to-full, pop-to-partial, pop-to-empty and flush-to-empty. A push and a pop in the same cycle leave the state unchanged.

Top module: `spi_rx_fifo`

## Requirements
- R1: After reset the count, the read index, both flags, `irq` and `dma_req` are all 0.
- R2: A push with room stores `push_data` and raises `count` by one. A pop of a non-empty queue lowers `count` by one. `pop_data` always shows the oldest stored word, so words leave in arrival order. `pop_ptr` advances by one per pop and wraps from 3 to 0.
- R3: With `ovr_en`=0, a push while full (and no pop in that cycle) is discarded. The count and the stored words stay unchanged.
- R4: With `ovr_en`=1, a push while full (and no pop in that cycle) replaces the most recently stored word. The count stays unchanged.
- R5: Flag bit 0 (overflow) sets on the edge where a push meets a full queue with no pop in that cycle. It stays set until a clear write with mask bit 0 = 1. A set in the same cycle wins over the clear.
- R6: Flag bit 1 (drain) is 1 whenever the count is non-zero, and a clear write cannot remove it then. Once the queue empties, the flag stays 1 until a clear write with mask bit 1 = 1.
- R7: `req_en` bit 0 enables the overflow interrupt. `req_en` bit 1 enables the drain request. The drain request drives `dma_req` when `drain_to_dma`=1 and drives `irq` otherwise. A request whose enable bit is 0 drives neither output.
- R8: `flush` sets the count and `pop_ptr` to 0 on the next edge. It takes priority over a push or pop in the same cycle.
- R9: With `bypass`=1 the queue holds at most one word. A second push without a pop is an overflow, handled by the drop or overwrite rule.
- R10: `dbg_data` shows the slot selected by `dbg_idx` (0 to 3) combinationally. Reading it has no effect on the queue.
- R11: A pop while empty has no effect on the count or `pop_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push | input | 1 | Word arriving from the shifter |
| push_data | input | 32 | Arriving word |
| pop | input | 1 | Register read strobe |
| pop_data | output | 32 | Oldest stored word |
| flush | input | 1 | Empty the queue |
| bypass | input | 1 | Single-slot operation |
| ovr_en | input | 1 | 1: overwrite on full, 0: drop on full |
| dbg_idx | input | 2 | Debug slot index |
| dbg_data | output | 32 | Content of the debug slot |
| count | output | 4 | Number of stored words |
| pop_ptr | output | 4 | Index of the next slot to pop |
| flag_clr | input | 1 | Flag clear write strobe |
| flag_clr_mask | input | 2 | Clear mask, 1 clears the flag at that bit |
| req_en | input | 2 | Request enables, bit 0 overflow, bit 1 drain |
| drain_to_dma | input | 1 | 1: drain goes to DMA, 0: to interrupt |
| flags | output | 2 | Bit 0 overflow, bit 1 drain |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The assertions assume that `bypass` changes only while the queue is empty and idle, since the single-slot bound would not hold otherwise. The stimulus toggles `bypass` only right after a flush. They also assume that `dbg_idx` stays within 0 to 3, which holds for its 2-bit width. The directed stimulus reaches each full-queue event with a known pop setting, so that the overflow and policy checks see an isolated push. `push` and `pop` are driven away from the clock edge as single-cycle strobes.

// File: rtl/spi_rx_fifo_pkg.sv
package spi_rx_fifo_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } fill_state_t;

    localparam int FLAG_OVF = 0;
    localparam int FLAG_DRN = 1;
    localparam int NFLAGS   = 2;

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    input  logic [PW-1:0] dbg_idx,
    output logic [DW-1:0] dbg_data
);

    logic [DW-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_idx == PW'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    assign rd_data  = slot_q[rd_idx];
    assign dbg_data = slot_q[dbg_idx];

endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
    import spi_rx_fifo_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic          bypass,
    input  logic          ovr_en,
    output logic          wr_en,
    output logic [PW-1:0] wr_idx,
    output logic [PW-1:0] rd_idx,
    output logic [CW-1:0] cnt,
    output logic          cnt_nz_next,
    output logic          ovf_evt
);

    fill_state_t   state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [PW-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
    logic [CW-1:0] cap;
    logic          is_full, is_empty;
    logic          pop_ok, push_ok, room, ovwr;

    assign cap = bypass ? CW'(1) : CW'(DEPTH);

    // Output decode from the current state
    always_comb begin
        is_full  = 1'b0;
        is_empty = 1'b0;
        unique case (state_q)
            ST_EMPTY:   is_empty = 1'b1;
            ST_PARTIAL: ;
            ST_FULL:    is_full  = 1'b1;
            default:    is_empty = 1'b1;
        endcase
    end

    assign pop_ok  = pop && !is_empty && !flush;
    assign room    = !is_full || pop_ok;
    assign push_ok = push && room && !flush;
    assign ovf_evt = push && !room && !flush;
    assign ovwr    = ovf_evt && ovr_en;

    assign wr_en  = push_ok || ovwr;
    assign wr_idx = bypass ? '0 : (push_ok ? wptr_q : wptr_q - PW'(1));
    assign rd_idx = bypass ? '0 : rptr_q;

    always_comb begin
        cnt_n  = cnt_q;
        wptr_n = wptr_q;
        rptr_n = rptr_q;
        if (flush) begin
            cnt_n  = '0;
            wptr_n = '0;
            rptr_n = '0;
        end else begin
            cnt_n = cnt_q + CW'(push_ok) - CW'(pop_ok);
            if (push_ok && !bypass) wptr_n = wptr_q + PW'(1);
            if (pop_ok && !bypass)  rptr_n = rptr_q + PW'(1);
        end
    end

    // Next-state logic: transitions named in the brief
    always_comb begin
        if (cnt_n == '0)      state_n = ST_EMPTY;   // pop-to-empty, flush-to-empty
        else if (cnt_n >= cap) state_n = ST_FULL;   // push-to-full
        else                  state_n = ST_PARTIAL; // push-to-partial, pop-to-partial
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            cnt_q  <= cnt_n;
            wptr_q <= wptr_n;
            rptr_q <= rptr_n;
        end
    end

    assign cnt         = cnt_q;
    assign cnt_nz_next = (cnt_n != '0);

endmodule

// File: rtl/rxf_flags.sv
module rxf_flags
    import spi_rx_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovf_evt,
    input  logic              cnt_nz_next,
    input  logic              clr,
    input  logic [NFLAGS-1:0] clr_mask,
    input  logic [NFLAGS-1:0] en,
    input  logic              to_dma,
    output logic [NFLAGS-1:0] flags,
    output logic              irq,
    output logic              dma_req
);

    logic [NFLAGS-1:0] flag_q, flag_n, kill;

    assign kill = clr ? clr_mask : '0;

    always_comb begin
        flag_n[FLAG_OVF] = ovf_evt     | (flag_q[FLAG_OVF] & ~kill[FLAG_OVF]);
        flag_n[FLAG_DRN] = cnt_nz_next | (flag_q[FLAG_DRN] & ~kill[FLAG_DRN]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_n;
    end

    logic drn_req;
    assign drn_req = flag_q[FLAG_DRN] & en[FLAG_DRN];

    assign flags   = flag_q;
    assign dma_req = drn_req & to_dma;
    assign irq     = (flag_q[FLAG_OVF] & en[FLAG_OVF]) | (drn_req & ~to_dma);

endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo
    import spi_rx_fifo_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    parameter int STW   = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DW-1:0]     push_data,
    input  logic              pop,
    output logic [DW-1:0]     pop_data,
    input  logic              flush,
    input  logic              bypass,
    input  logic              ovr_en,
    input  logic [PW-1:0]     dbg_idx,
    output logic [DW-1:0]     dbg_data,
    output logic [STW-1:0]    count,
    output logic [STW-1:0]    pop_ptr,
    input  logic              flag_clr,
    input  logic [NFLAGS-1:0] flag_clr_mask,
    input  logic [NFLAGS-1:0] req_en,
    input  logic              drain_to_dma,
    output logic [NFLAGS-1:0] flags,
    output logic              irq,
    output logic              dma_req
);

    logic          wr_en, cnt_nz_next, ovf_evt;
    logic [PW-1:0] wr_idx, rd_idx;
    logic [CW-1:0] cnt;

    rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (push),
        .pop         (pop),
        .flush       (flush),
        .bypass      (bypass),
        .ovr_en      (ovr_en),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .rd_idx      (rd_idx),
        .cnt         (cnt),
        .cnt_nz_next (cnt_nz_next),
        .ovf_evt     (ovf_evt)
    );

    rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (push_data),
        .rd_idx   (rd_idx),
        .rd_data  (pop_data),
        .dbg_idx  (dbg_idx),
        .dbg_data (dbg_data)
    );

    rxf_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .ovf_evt     (ovf_evt),
        .cnt_nz_next (cnt_nz_next),
        .clr         (flag_clr),
        .clr_mask    (flag_clr_mask),
        .en          (req_en),
        .to_dma      (drain_to_dma),
        .flags       (flags),
        .irq         (irq),
        .dma_req     (dma_req)
    );

    assign count   = STW'(cnt);
    assign pop_ptr = STW'(rd_idx);

endmodule

// File: rtl/spi_rx_fifo_chk.sv
module spi_rx_fifo_chk #(
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    parameter int STW   = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           push,
    input logic           pop,
    input logic           flush,
    input logic           bypass,
    input logic           ovr_en,
    input logic           flag_clr,
    input logic [1:0]     flag_clr_mask,
    input logic [1:0]     req_en,
    input logic           drain_to_dma,
    input logic [DW-1:0]  pop_data,
    input logic [STW-1:0] count,
    input logic [STW-1:0] pop_ptr,
    input logic [1:0]     flags,
    input logic           irq,
    input logic           dma_req
);

    localparam logic [STW-1:0] FULLC = STW'(DEPTH);

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULLC);

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0) && (pop_ptr == '0));

    a_r6_drain_while_data: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |-> flags[1]);

    a_r5_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush && !bypass && count == FULLC) |=> flags[0]);

    a_r3_drop_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush && !bypass && !ovr_en && count == FULLC)
        |=> (count == FULLC) && $stable(pop_data) && $stable(pop_ptr));

    a_r7_dma_routing: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (flags[1] && req_en[1] && drain_to_dma && !(irq && !flags[0])));

    a_r11_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && count == '0) |=> (count == '0) && $stable(pop_ptr));

    a_r9_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> (count <= STW'(1)));

endmodule

bind spi_rx_fifo spi_rx_fifo_chk #(.DEPTH(DEPTH), .DW(DW), .STW(STW)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .push          (push),
    .pop           (pop),
    .flush         (flush),
    .bypass        (bypass),
    .ovr_en        (ovr_en),
    .flag_clr      (flag_clr),
    .flag_clr_mask (flag_clr_mask),
    .req_en        (req_en),
    .drain_to_dma  (drain_to_dma),
    .pop_data      (pop_data),
    .count         (count),
    .pop_ptr       (pop_ptr),
    .flags         (flags),
    .irq           (irq),
    .dma_req       (dma_req)
);

// File: tb/test_spi_rx_fifo.sv
module test_spi_rx_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push = 1'b0, pop = 1'b0, flush = 1'b0, bypass = 1'b0, ovr_en = 1'b0;
    logic [31:0] push_data = '0;
    logic [1:0]  dbg_idx = '0;
    logic        flag_clr = 1'b0;
    logic [1:0]  flag_clr_mask = '0, req_en = '0;
    logic        drain_to_dma = 1'b0;
    logic [31:0] pop_data, dbg_data;
    logic [3:0]  count, pop_ptr;
    logic [1:0]  flags;
    logic        irq, dma_req;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_rx_fifo i_spi_rx_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
        .pop_data(pop_data), .flush(flush), .bypass(bypass), .ovr_en(ovr_en),
        .dbg_idx(dbg_idx), .dbg_data(dbg_data), .count(count), .pop_ptr(pop_ptr),
        .flag_clr(flag_clr), .flag_clr_mask(flag_clr_mask), .req_en(req_en),
        .drain_to_dma(drain_to_dma), .flags(flags), .irq(irq), .dma_req(dma_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_push(input logic [31:0] d);
        push = 1'b1; push_data = d;
        @(negedge clk);
        push = 1'b0;
    endtask

    task automatic do_pop();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic do_clr(input logic [1:0] m);
        flag_clr = 1'b1; flag_clr_mask = m;
        @(negedge clk);
        flag_clr = 1'b0; flag_clr_mask = '0;
    endtask

    task automatic clean();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        do_clr(2'b11);
    endtask

    task automatic t_reset();
        chk("R1 count", 32'(count), 0);
        chk("R1 pop_ptr", 32'(pop_ptr), 0);
        chk("R1 flags", 32'(flags), 0);
        chk("R1 irq/dma", {30'd0, irq, dma_req}, 0);
    endtask

    task automatic t_order();
        clean();
        for (int i = 0; i < 4; i++) do_push(32'hA000_0000 + 32'(i));
        chk("R2 count full", 32'(count), 4);
        for (int i = 0; i < 4; i++) begin
            chk("R2 pop_data order", pop_data, 32'hA000_0000 + 32'(i));
            chk("R2 pop_ptr", 32'(pop_ptr), 32'(i));
            do_pop();
        end
        chk("R2 count empty, ptr wrap", {count, pop_ptr}, 0);
    endtask

    task automatic t_drop();
        clean();
        ovr_en = 1'b0;
        for (int i = 0; i < 4; i++) do_push(32'hB0 + 32'(i));
        do_push(32'hDEAD);
        chk("R3 count kept", 32'(count), 4);
        chk("R5 overflow set", 32'(flags[0]), 1);
        dbg_idx = 2'd3; #1;
        chk("R3 last slot kept", dbg_data, 32'hB3);
        for (int i = 0; i < 4; i++) begin
            chk("R3 drained word", pop_data, 32'hB0 + 32'(i));
            do_pop();
        end
    endtask

    task automatic t_overwrite();
        clean();
        ovr_en = 1'b1;
        for (int i = 0; i < 4; i++) do_push(32'hC0 + 32'(i));
        do_push(32'hBEEF);
        ovr_en = 1'b0;
        chk("R4 count kept", 32'(count), 4);
        for (int i = 0; i < 3; i++) begin
            chk("R4 old word", pop_data, 32'hC0 + 32'(i));
            do_pop();
        end
        chk("R4 newest replaced", pop_data, 32'hBEEF);
        do_pop();
    endtask

    task automatic t_flags();
        clean();
        do_push(32'h1);
        chk("R6 drain set with data", 32'(flags[1]), 1);
        do_clr(2'b10);
        chk("R6 drain not clearable while data", 32'(flags[1]), 1);
        do_pop();
        chk("R6 drain sticky after empty", 32'(flags[1]), 1);
        do_clr(2'b10);
        chk("R6 drain cleared", 32'(flags[1]), 0);
        for (int i = 0; i < 5; i++) do_push(32'(i));
        chk("R5 overflow flag", 32'(flags[0]), 1);
        do_clr(2'b10);
        chk("R5 overflow survives other mask", 32'(flags[0]), 1);
        do_clr(2'b01);
        chk("R5 overflow cleared", 32'(flags[0]), 0);
        // pop with push on full: no overflow
        pop = 1'b1; push = 1'b1; push_data = 32'h77;
        @(negedge clk);
        pop = 1'b0; push = 1'b0;
        chk("R5 pop frees room", {28'd0, count}, 4);
        chk("R5 no overflow with pop", 32'(flags[0]), 0);
    endtask

    task automatic t_route();
        clean();
        do_push(32'h5);
        req_en = 2'b10; drain_to_dma = 1'b1; #1;
        chk("R7 drain to dma", {30'd0, irq, dma_req}, 1);
        drain_to_dma = 1'b0; #1;
        chk("R7 drain to irq", {30'd0, irq, dma_req}, 2);
        req_en = 2'b00; #1;
        chk("R7 disabled", {30'd0, irq, dma_req}, 0);
        for (int i = 0; i < 4; i++) do_push(32'(i));
        req_en = 2'b01; drain_to_dma = 1'b1; #1;
        chk("R7 overflow irq only", {30'd0, irq, dma_req}, 2);
        req_en = 2'b00; drain_to_dma = 1'b0;
    endtask

    task automatic t_flush();
        clean();
        do_push(32'h11); do_push(32'h22); do_pop();
        flush = 1'b1; push = 1'b1; push_data = 32'h33;
        @(negedge clk);
        flush = 1'b0; push = 1'b0;
        chk("R8 flush beats push", {count, pop_ptr}, 0);
    endtask

    task automatic t_bypass();
        clean();
        bypass = 1'b1;
        do_push(32'hE1);
        chk("R9 one word", 32'(count), 1);
        do_push(32'hE2);
        chk("R9 second is overflow", {30'd0, flags[0], 1'b0}, 2);
        chk("R9 first kept", pop_data, 32'hE1);
        do_pop();
        chk("R9 empty", 32'(count), 0);
        flush = 1'b1; @(negedge clk); flush = 1'b0;
        bypass = 1'b0;
    endtask

    task automatic t_debug();
        clean();
        for (int i = 0; i < 3; i++) do_push(32'hD0 + 32'(i));
        for (int i = 0; i < 3; i++) begin
            dbg_idx = 2'(i); #1;
            chk("R10 debug slot", dbg_data, 32'hD0 + 32'(i));
        end
        chk("R10 no side effect", 32'(count), 3);
    endtask

    task automatic t_pop_empty();
        clean();
        do_pop();
        chk("R11 pop empty", {count, pop_ptr}, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_drop();
        t_overwrite();
        t_flags();
        t_route();
        t_flush();
        t_bypass();
        t_debug();
        t_pop_empty();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule